// File: doc/BRIEF.md
# Dual-Path Interrupt Controller

This block gathers level-held interrupt requests from eleven on-chip and off-chip sources, together with a bit that software can raise, and steers them to the CPU core through two separate paths. One path drives the normal interrupt line (IRQ) and the other drives the fast interrupt line (FIQ). Each source has a fixed bit position, and that position is the same in every register of both paths. Each path has its own enable bits, so a source can be routed to either line, to both lines, or to neither.

Software sees nine word registers on a simple read/write bus. Each path has four of them: a raw view of the request lines, a set-enable register, a clear-enable register and a masked status view. The ninth register raises the software interrupt. The request lines are only sampled. The controller cannot clear a request, because the peripheral drops its own line when its flag is serviced. The IRQ and FIQ outputs are registered, so each is a clean level that follows its path's status one clock later.

Top module: `intc_dual_path`

## Requirements
- R1: Request input `periphReq[i]` for i in 0..9 appears at bit i+2 of both raw views, and `periphReq[10]` appears at bit 13. Bits 12 and 14..31 read as zero in every register.
- R2: Bit 0 reads as zero in all IRQ registers. In the FIQ raw view, bit 0 is the OR of all raw sources, including the software bit. In the FIQ status view, bit 0 is the OR of all FIQ status bits.
- R3: Writing 1 to a bit of a path's set-enable register sets that enable bit. Writing 0 leaves it unchanged. Reading the set-enable address returns the current enables.
- R4: Writing 1 to a bit of a path's clear-enable register clears that enable bit. Writing 0 leaves it unchanged. The clear-enable address reads as zero.
- R5: Only bits 2..11 and 13 can be enabled. Bit 1 (software), bit 0 and the reserved bits always stay zero in both enable registers.
- R6: A path's status view equals its raw sources ANDed with that path's enables.
- R7: `irqOut` and `fiqOut` are the OR of their path's status bits, registered: they change on the clock edge after the status changes. A source that is not enabled in a path never raises that path's output.
- R8: The two paths are independent. Enabling a source in both paths asserts both outputs, and changing one path's enables does not affect the other path.
- R9: After reset, all enables are zero, the software bit is zero and both outputs are low.
- R10: Writing bit 1 of the software-trigger register sets or clears the software raw bit (bit 1 of both raw views). The software-trigger register reads back that bit at bit 1.
- R11: Writes to the raw and status addresses have no effect. A raw bit follows its request line and falls only when that line falls.
- R12: Word offsets on `busAddr`: 0 IRQ raw, 1 IRQ set-enable, 2 IRQ clear-enable, 3 IRQ status, 4 FIQ raw, 5 FIQ set-enable, 6 FIQ clear-enable, 7 FIQ status, 8 software trigger. All other offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphReq | input | 11 | Level-held request lines from the sources |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 4 | Register word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational from `busAddr`) |
| irqOut | output | 1 | Registered normal interrupt request |
| fiqOut | output | 1 | Registered fast interrupt request |

## Verification
The bench writes all ones to the set-enable registers and expects to read back only the source mask. A design that let bit 1 or a reserved bit become enabled would show the extra bits in that read-back. It would also raise an output from the software trigger. The bench checks the output both one edge and two edges after an enable write, so an unregistered output, or one delayed by an extra stage, is reported. A source is enabled in one path only while the other path is checked, and bit 0 is compared between the IRQ and FIQ views, to catch crossed banks or a summary bit leaking into the IRQ registers. Writes to the raw and status addresses while a line is held must leave the line visible, which catches a controller that clears requests on its own.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W   = 32;
  localparam int PERIPH_N = 11;
  localparam int ADDR_W   = 4;
  localparam int PATHS    = 2;   // 0: normal, 1: fast
  localparam int SW_BIT   = 1;
  localparam int ANY_BIT  = 0;
  localparam int ON_CHIP_N = 10; // sources packed from bit 2 upward
  localparam int EXT_POS  = 13;

  localparam logic [ADDR_W-1:0] A_IRQ_RAW  = 4'd0;
  localparam logic [ADDR_W-1:0] A_IRQ_SET  = 4'd1;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 4'd3;
  localparam logic [ADDR_W-1:0] A_FIQ_RAW  = 4'd4;
  localparam logic [ADDR_W-1:0] A_FIQ_SET  = 4'd5;
  localparam logic [ADDR_W-1:0] A_FIQ_CLR  = 4'd6;
  localparam logic [ADDR_W-1:0] A_FIQ_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_SW_TRIG  = 4'd8;

  function automatic int srcPos(input int idx);
    return (idx < ON_CHIP_N) ? idx + 2 : EXT_POS;
  endfunction

  function automatic logic [DATA_W-1:0] buildMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < PERIPH_N; i++) m[srcPos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] EN_MASK = buildMask();

  typedef struct packed {
    logic [PATHS-1:0] enSet;
    logic [PATHS-1:0] enClr;
    logic             swWr;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic wrEn;
  assign wrEn = busSel && busWr;

  always_comb begin
    stb          = '0;
    stb.enSet[0] = wrEn && (busAddr == A_IRQ_SET);
    stb.enSet[1] = wrEn && (busAddr == A_FIQ_SET);
    stb.enClr[0] = wrEn && (busAddr == A_IRQ_CLR);
    stb.enClr[1] = wrEn && (busAddr == A_FIQ_CLR);
    stb.swWr     = wrEn && (busAddr == A_SW_TRIG);
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIPH_N-1:0] periphReq,
  input  strobe_t             stb,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irqOut,
  output logic                fiqOut,
  output logic [DATA_W-1:0]   irqEnQ,
  output logic [DATA_W-1:0]   fiqEnQ,
  output logic [DATA_W-1:0]   rawVec
);
  logic [PATHS-1:0][DATA_W-1:0] enQ;
  logic [PATHS-1:0][DATA_W-1:0] stat;
  logic [PATHS-1:0]             outQ;
  logic                         swQ;
  logic [DATA_W-1:0]            rawSrc;
  logic [DATA_W-1:0]            wrBits;

  assign wrBits = busWdata & EN_MASK;

  always_comb begin
    rawSrc = '0;
    for (int i = 0; i < PERIPH_N; i++) rawSrc[srcPos(i)] = periphReq[i];
    rawSrc[SW_BIT] = swQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         swQ <= 1'b0;
    else if (stb.swWr) swQ <= busWdata[SW_BIT];
  end

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               enQ[p] <= '0;
      else if (stb.enSet[p])   enQ[p] <= enQ[p] | wrBits;
      else if (stb.enClr[p])   enQ[p] <= enQ[p] & ~wrBits;
    end

    assign stat[p] = rawSrc & enQ[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outQ[p] <= 1'b0;
      else       outQ[p] <= |stat[p];
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_IRQ_RAW:  busRdata = rawSrc;
      A_IRQ_SET:  busRdata = enQ[0];
      A_IRQ_STAT: busRdata = stat[0];
      A_FIQ_RAW:  busRdata = rawSrc | {{(DATA_W-1){1'b0}}, |rawSrc};
      A_FIQ_SET:  busRdata = enQ[1];
      A_FIQ_STAT: busRdata = stat[1] | {{(DATA_W-1){1'b0}}, |stat[1]};
      A_SW_TRIG:  busRdata[SW_BIT] = swQ;
      default:    busRdata = '0;
    endcase
  end

  assign irqOut = outQ[0];
  assign fiqOut = outQ[1];
  assign irqEnQ = enQ[0];
  assign fiqEnQ = enQ[1];
  assign rawVec = rawSrc;
endmodule

// File: rtl/intc_dual_path.sv
module intc_dual_path
  import intc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIPH_N-1:0] periphReq,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irqOut,
  output logic                fiqOut
);
  strobe_t           stb;
  logic [DATA_W-1:0] irqEnQ;
  logic [DATA_W-1:0] fiqEnQ;
  logic [DATA_W-1:0] rawVec;

  intc_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  intc_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .periphReq(periphReq),
    .stb      (stb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut),
    .irqEnQ   (irqEnQ),
    .fiqEnQ   (fiqEnQ),
    .rawVec   (rawVec)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              fiqOut,
  input logic [DATA_W-1:0] irqEnQ,
  input logic [DATA_W-1:0] fiqEnQ,
  input logic [DATA_W-1:0] rawVec
);
  localparam logic [DATA_W-1:0] RAW_OK = EN_MASK | (DATA_W'(1) << SW_BIT);

  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rawVec & ~RAW_OK) == '0);

  assert_irq_bit0_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr <= A_IRQ_STAT) |-> (busRdata[ANY_BIT] == 1'b0));

  assert_set_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == A_IRQ_SET) |=>
      ((irqEnQ & $past(busWdata) & EN_MASK) == ($past(busWdata) & EN_MASK)));

  assert_clr_fiq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == A_FIQ_CLR) |=>
      ((fiqEnQ & $past(busWdata) & EN_MASK) == '0));

  assert_en_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((irqEnQ | fiqEnQ) & ~EN_MASK) == '0);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((irqEnQ & rawVec) == '0) |=> !irqOut);

  assert_fiq_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((fiqEnQ & rawVec) == '0) |=> !fiqOut);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((irqEnQ & rawVec) != '0) |=> irqOut);
endmodule

bind intc_dual_path intc_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut),
  .irqEnQ  (irqEnQ),
  .fiqEnQ  (fiqEnQ),
  .rawVec  (rawVec)
);

// File: tb/intc_dual_path_bench.sv
module intc_dual_path_bench;
  localparam logic [31:0] MASK = 32'h0000_2FFC;

  typedef struct packed {
    logic [10:0] req;
    logic [31:0] irqEn;
    logic [31:0] fiqEn;
    logic        expIrq;
    logic        expFiq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{11'h000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{11'h001, 32'h0000_0004, 32'h0000_0000, 1'b1, 1'b0},
    '{11'h001, 32'h0000_0000, 32'h0000_0004, 1'b0, 1'b1},
    '{11'h400, 32'h0000_2000, 32'h0000_2000, 1'b1, 1'b1},
    '{11'h200, 32'h0000_0400, 32'h0000_0000, 1'b0, 1'b0},
    '{11'h7FF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    '{11'h100, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] periphReq = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  intc_dual_path u_intc_dual_path (
    .clk(clk), .rstN(rstN), .periphReq(periphReq),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic logic [31:0] mapReq(input logic [10:0] r);
    logic [31:0] m;
    m = {18'd0, r[10], 1'b0, r[9:0], 2'b00};
    return m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d, exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 irqOut", {31'd0, irqOut}, 32'd0);
    check("R9 fiqOut", {31'd0, fiqOut}, 32'd0);
    rd(4'd1, d); check("R9 irq enables", d, 32'd0);
    rd(4'd5, d); check("R9 fiq enables", d, 32'd0);
    rd(4'd8, d); check("R9 sw bit", d, 32'd0);

    // vector table: R6 R7 R8 R1
    foreach (VECS[i]) begin
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd1, VECS[i].irqEn);
      wr(4'd5, VECS[i].fiqEn);
      periphReq = VECS[i].req;
      @(negedge clk);
      check($sformatf("R7 R8 irqOut vec%0d", i), {31'd0, irqOut}, {31'd0, VECS[i].expIrq});
      check($sformatf("R7 R8 fiqOut vec%0d", i), {31'd0, fiqOut}, {31'd0, VECS[i].expFiq});
      rd(4'd0, d); check($sformatf("R1 irq raw vec%0d", i), d, mapReq(VECS[i].req));
      exp = mapReq(VECS[i].req) & VECS[i].irqEn & MASK;
      rd(4'd3, d); check($sformatf("R6 irq status vec%0d", i), d, exp);
      exp = mapReq(VECS[i].req) & VECS[i].fiqEn & MASK;
      exp[0] = |exp;
      rd(4'd7, d); check($sformatf("R6 R2 fiq status vec%0d", i), d, exp);
    end

    // R5 only source bits enable
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd6, 32'hFFFF_FFFF);
    periphReq = '0;
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, d); check("R5 irq enable mask", d, MASK);
    rd(4'd5, d); check("R8 fiq enables untouched", d, 32'd0);
    rd(4'd2, d); check("R4 clear addr reads zero", d, 32'd0);

    // R3 writing zero to set-enable keeps bits
    wr(4'd1, 32'h0);
    rd(4'd1, d); check("R3 zero write keeps", d, MASK);
    // R4 clear selected bits
    wr(4'd2, 32'h0000_0014);
    rd(4'd1, d); check("R4 partial clear", d, MASK & ~32'h14);
    wr(4'd2, 32'h0);
    rd(4'd1, d); check("R4 zero write keeps", d, MASK & ~32'h14);

    // R10 software trigger, cannot reach outputs (R5)
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd8, 32'h0000_0002);
    rd(4'd8, d); check("R10 sw readback", d, 32'h2);
    rd(4'd0, d); check("R10 irq raw sw", d, 32'h2);
    rd(4'd4, d); check("R2 fiq raw any", d, 32'h3);
    @(negedge clk);
    check("R5 sw gives no irq", {31'd0, irqOut}, 32'd0);
    check("R5 sw gives no fiq", {31'd0, fiqOut}, 32'd0);
    wr(4'd8, 32'h0);
    rd(4'd4, d); check("R10 sw cleared", d, 32'd0);

    // R7 registered timing
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd6, 32'hFFFF_FFFF);
    periphReq = 11'h004;            // bit 4
    @(negedge clk);
    wr(4'd1, 32'h0000_0010);
    check("R7 out not same edge", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    check("R7 out next edge", {31'd0, irqOut}, 32'd1);

    // R11 writes to raw/status do not clear
    wr(4'd0, 32'h0); wr(4'd3, 32'hFFFF_FFFF); wr(4'd4, 32'h0); wr(4'd7, 32'h0);
    rd(4'd0, d); check("R11 raw held", d, 32'h10);
    rd(4'd3, d); check("R11 status held", d, 32'h10);
    periphReq = '0;
    @(negedge clk);
    rd(4'd0, d); check("R11 raw falls with line", d, 32'd0);
    @(negedge clk);
    check("R11 out falls", {31'd0, irqOut}, 32'd0);

    // R12 unused offsets
    rd(4'd9, d);  check("R12 offset 9", d, 32'd0);
    rd(4'd15, d); check("R12 offset 15", d, 32'd0);

    summary();
  end
endmodule